// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block drives the bus cycles a small 8-bit accumulator-style CPU core performs when it enters an exception handler. The core reports each instruction boundary. It also reports whether the completing instruction was one of the two software traps, "break" and "coprocessor". Alongside these come the core's current program counter, the start address of the current instruction, the program bank byte, the status byte, the stack pointer and the native/emulation mode bit. The sequencer weighs these against four active-low hardware request lines: reset, abort, non-maskable and maskable. When an entry is due, it raises `busy` so that the core stalls, writes the return context to the stack one byte per cycle, and reads the two-byte handler address from a fixed vector location. In the final cycle it hands the core a new program counter, status byte, mode bit and stack pointer.

A hardware reset request bypasses the stack entirely. After the request is released, the block counts out a fixed initialisation period and then fetches the reset vector. An abort is different from the other entries. The block flags at the boundary that the completing instruction's results must be thrown away, and it saves that instruction's own start address, so a return from the handler runs the instruction again. Memory reads in the vector cycles are combinational: `mem_rdata` must be valid in the same cycle as `mem_re`.

Top module: `irq_entry_seq`

## Requirements
- R1: While `hw_reset_n` is low the block holds in initialisation with no stack writes. Once it is released, exactly INIT_CYCLES (default 6) cycles pass before a vector read at 0xFFFC, followed by the high byte at 0xFFFD. The load then reports `native_out`=0, status bit 2 (interrupt disable) set and bit 3 (decimal) clear.
- R2: In native mode an entry writes four bytes at stack addresses SP, SP-1, SP-2 and SP-3, in this order: bank byte, return address high, return address low, saved status.
- R3: In emulation mode an entry writes three bytes: return high, return low, saved status. Each address is 0x01 in the high byte and the stack pointer's low byte in the low byte, decremented once per byte and wrapping from 0x00 to 0xFF without leaving page 0x01.
- R4: A low `irq_n` with status bit 2 set at a boundary causes no entry: `busy` stays low and nothing is written.
- R5: An abort (`abort_n` low at or before a boundary) raises `squash` in the boundary cycle, and the saved return address is `insn_start`.
- R6: For a break or coprocessor trap with no hardware request at the same boundary, the saved return address is `insn_start` + 2.
- R7: In emulation mode the saved status equals the input status with bit 5 forced to 1 and bit 4 set for a software trap, clear for a hardware entry. In native mode the saved status is the input status unchanged.
- R8: The vector address (low byte first, high byte at +1) is as follows. In emulation mode: abort 0xFFF8, non-maskable 0xFFFA, maskable and break 0xFFFE, coprocessor 0xFFF4. In native mode: abort 0xFFE8, non-maskable 0xFFEA, maskable 0xFFEE, break 0xFFE6, coprocessor 0xFFE4. `pc_new` is {high byte, low byte}.
- R9: When `pc_load` is high, `status_out` equals the captured status with bit 2 set and bit 3 cleared, and `native_out` equals the mode in force at entry.
- R10: When several requests coincide, entry priority runs reset, then abort, then non-maskable, then maskable, then break, then coprocessor.
- R11: A non-maskable request is a high-to-low transition on `nmi_n`. It is held pending until it is serviced at a boundary, and it ignores status bit 2. A line held low does not request again.
- R12: A hardware request taken at the same boundary as a trap saves `insn_start` as the return address, so the trap is executed again after the handler returns.
- R13: With `pc_load`, `sp_out` is the stack pointer after all pushes: SP-4 in native mode, or page 0x01 with the low byte decremented by three in emulation mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset, released synchronously inside |
| hw_reset_n | input | 1 | Active-low processor reset request |
| nmi_n | input | 1 | Active-low non-maskable request, edge detected |
| irq_n | input | 1 | Active-low maskable request, level sampled at boundary |
| abort_n | input | 1 | Active-low abort request |
| brk_trap | input | 1 | Completing instruction is a break trap |
| cop_trap | input | 1 | Completing instruction is a coprocessor trap |
| insn_done | input | 1 | Instruction boundary strobe |
| cur_pc | input | 16 | Address of the next instruction |
| insn_start | input | 16 | Start address of the completing instruction |
| bank_in | input | 8 | Program bank byte |
| status_in | input | 8 | Status byte |
| native_in | input | 1 | 1 = native mode, 0 = emulation mode |
| sp_in | input | 16 | Stack pointer |
| mem_rdata | input | 8 | Combinational read data for vector fetch |
| busy | output | 1 | Sequence in progress, core must stall |
| squash | output | 1 | Discard results of the completing instruction |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Vector read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Stack write data |
| pc_load | output | 1 | Load new context this cycle |
| pc_new | output | 16 | Handler address |
| status_out | output | 8 | New status byte |
| native_out | output | 1 | New mode bit |
| sp_out | output | 16 | New stack pointer |

## Verification
The properties assume that the core holds `insn_done` low while `busy` is high. They also assume the stack pointer and mode inputs are stable for the single boundary cycle, and that `mem_rdata` answers in the same cycle as `mem_re`. The bench meets these assumptions by raising `insn_done` for exactly one cycle per entry. It returns every request line to its idle level on the next cycle and waits for `pc_load` before it starts the next boundary. Its memory model derives the read byte from the address, so every vector value is known in advance.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    C_NONE, C_RST, C_ABT, C_NMI, C_IRQ, C_BRK, C_COP
  } cause_e;

  typedef enum logic [2:0] {
    S_IDLE, S_INIT, S_PB, S_PH, S_PL, S_PP, S_VLO, S_VHI
  } state_e;

  localparam int FL_I = 2;  // interrupt disable
  localparam int FL_D = 3;  // decimal mode
  localparam int FL_B = 4;  // software-trap marker in saved copy
  localparam int FL_U = 5;  // always-one bit in emulation copy
endpackage

// File: rtl/irq_req_arb.sv
module irq_req_arb
  import irq_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hw_reset_n,
  input  logic   nmi_n,
  input  logic   irq_n,
  input  logic   abort_n,
  input  logic   brk_trap,
  input  logic   cop_trap,
  input  logic   irq_mask,
  input  logic   boundary,
  output cause_e cause
);
  logic nmi_prev_q, nmi_pend_q, abt_pend_q;
  logic nmi_pend_d, abt_pend_d;
  logic nmi_fall, abt_req;

  assign nmi_fall = nmi_prev_q & ~nmi_n;
  assign abt_req  = abt_pend_q | ~abort_n;

  // fixed priority selection
  always_comb begin
    cause = C_NONE;
    if (!hw_reset_n)                 cause = C_RST;
    else if (boundary) begin
      if (abt_req)                   cause = C_ABT;
      else if (nmi_pend_q)           cause = C_NMI;
      else if (!irq_n && !irq_mask)  cause = C_IRQ;
      else if (brk_trap)             cause = C_BRK;
      else if (cop_trap)             cause = C_COP;
    end
  end

  always_comb begin
    if (!hw_reset_n) begin
      nmi_pend_d = 1'b0;
      abt_pend_d = 1'b0;
    end else begin
      nmi_pend_d = (nmi_pend_q & ~(cause == C_NMI)) | nmi_fall;
      abt_pend_d = abt_req & ~(cause == C_ABT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b1;
      nmi_pend_q <= 1'b0;
      abt_pend_q <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_n;
      nmi_pend_q <= nmi_pend_d;
      abt_pend_q <= abt_pend_d;
    end
  end
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  cause_e              cause,
  input  logic                native,
  output logic [ADDR_W-1:0]   vec
);
  logic [7:0] lo;

  always_comb begin
    unique case (cause)
      C_RST:   lo = 8'hFC;
      C_ABT:   lo = native ? 8'hE8 : 8'hF8;
      C_NMI:   lo = native ? 8'hEA : 8'hFA;
      C_BRK:   lo = native ? 8'hE6 : 8'hFE;
      C_COP:   lo = native ? 8'hE4 : 8'hF4;
      default: lo = native ? 8'hEE : 8'hFE;
    endcase
  end

  assign vec = {{(ADDR_W-8){1'b1}}, lo};
endmodule

// File: rtl/irq_stack_addr.sv
module irq_stack_addr #(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] PAGE   = 8'h01
) (
  input  logic [ADDR_W-1:0] sp,
  input  logic              native,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] nxt
);
  logic [7:0] lo_dec;

  assign lo_dec = sp[7:0] - 8'd1;
  assign addr   = native ? sp : ADDR_W'({PAGE, sp[7:0]});
  assign nxt    = native ? sp - ADDR_W'(1) : ADDR_W'({PAGE, lo_dec});
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 8,
  parameter int         INIT_CYCLES = 6,
  parameter logic [7:0] STACK_PAGE  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset_n,
  input  logic              nmi_n,
  input  logic              irq_n,
  input  logic              abort_n,
  input  logic              brk_trap,
  input  logic              cop_trap,
  input  logic              insn_done,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] insn_start,
  input  logic [DATA_W-1:0] bank_in,
  input  logic [7:0]        status_in,
  input  logic              native_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              squash,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_new,
  output logic [7:0]        status_out,
  output logic              native_out,
  output logic [ADDR_W-1:0] sp_out
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  state_e              state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  cause_e              cause, cause_q;
  logic                nat_q;
  logic [7:0]          stat_q;
  logic [DATA_W-1:0]   bank_q, vlo_q;
  logic [ADDR_W-1:0]   ret_q, ret_sel, sp_q, sp_init;
  logic [ADDR_W-1:0]   stk_addr, stk_nxt, vec;
  logic                boundary, take, rst_hit, ctx_ld, push, sw_trap;
  logic [7:0]          saved_stat;

  assign boundary = (state_q == S_IDLE) & insn_done;
  assign rst_hit  = (cause == C_RST);
  assign take     = boundary & (cause != C_NONE) & ~rst_hit;
  assign ctx_ld   = take | rst_hit;
  assign push     = (state_q == S_PB) | (state_q == S_PH) |
                    (state_q == S_PL) | (state_q == S_PP);

  irq_req_arb u_arb (
    .clk, .rst_n(rst_s_n), .hw_reset_n, .nmi_n, .irq_n, .abort_n,
    .brk_trap, .cop_trap, .irq_mask(status_in[FL_I]), .boundary, .cause
  );

  irq_vec_sel #(.ADDR_W(ADDR_W)) u_vec (
    .cause(cause_q), .native(nat_q), .vec
  );

  irq_stack_addr #(.ADDR_W(ADDR_W), .PAGE(STACK_PAGE)) u_stk (
    .sp(sp_q), .native(nat_q), .addr(stk_addr), .nxt(stk_nxt)
  );

  // return address: abort and coinciding hardware entries replay the instruction
  always_comb begin
    unique case (cause)
      C_ABT:        ret_sel = insn_start;
      C_BRK, C_COP: ret_sel = insn_start + ADDR_W'(2);
      default:      ret_sel = (brk_trap | cop_trap) ? insn_start : cur_pc;
    endcase
  end

  assign sp_init = (native_in & ~rst_hit) ? sp_in
                                          : ADDR_W'({STACK_PAGE, sp_in[7:0]});

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (rst_hit) begin
      state_d = S_INIT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (take) state_d = native_in ? S_PB : S_PH;
        S_INIT: begin
          if (cnt_q == CNT_W'(INIT_CYCLES - 1)) state_d = S_VLO;
          else                                  cnt_d   = cnt_q + CNT_W'(1);
        end
        S_PB:    state_d = S_PH;
        S_PH:    state_d = S_PL;
        S_PL:    state_d = S_PP;
        S_PP:    state_d = S_VLO;
        S_VLO:   state_d = S_VHI;
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // context capture, clock-enabled
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cause_q <= C_NONE;
      nat_q   <= 1'b0;
      stat_q  <= '0;
      bank_q  <= '0;
      ret_q   <= '0;
    end else if (ctx_ld) begin
      cause_q <= cause;
      nat_q   <= native_in & ~rst_hit;
      stat_q  <= status_in;
      bank_q  <= bank_in;
      ret_q   <= ret_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                 sp_q <= '0;
    else if (ctx_ld)              sp_q <= sp_init;
    else if (push)                sp_q <= stk_nxt;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                 vlo_q <= '0;
    else if (state_q == S_VLO)    vlo_q <= mem_rdata;
  end

  // saved status image
  assign sw_trap = (cause_q == C_BRK) | (cause_q == C_COP);
  always_comb begin
    saved_stat = stat_q;
    if (!nat_q) begin
      saved_stat[FL_U] = 1'b1;
      saved_stat[FL_B] = sw_trap;
    end
  end

  // bus outputs
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      S_PB:  begin mem_addr = stk_addr; mem_wdata = bank_q;                end
      S_PH:  begin mem_addr = stk_addr; mem_wdata = ret_q[15:8];           end
      S_PL:  begin mem_addr = stk_addr; mem_wdata = ret_q[7:0];            end
      S_PP:  begin mem_addr = stk_addr; mem_wdata = saved_stat;            end
      S_VLO: mem_addr = vec;
      S_VHI: mem_addr = vec + ADDR_W'(1);
      default: ;
    endcase
  end

  assign busy       = (state_q != S_IDLE);
  assign squash     = take & (cause == C_ABT);
  assign mem_we     = push;
  assign mem_re     = (state_q == S_VLO) | (state_q == S_VHI);
  assign pc_load    = (state_q == S_VHI);
  assign pc_new     = {mem_rdata, vlo_q};
  assign native_out = nat_q;
  assign sp_out     = sp_q;

  always_comb begin
    status_out       = stat_q;
    status_out[FL_I] = 1'b1;
    status_out[FL_D] = 1'b0;
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int         ADDR_W = 16,
  parameter logic [7:0] PAGE   = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_reset_n,
  input logic              busy,
  input logic              squash,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pc_load,
  input logic [7:0]        status_out,
  input logic              nat_q
);
  // R2/R3: pushes run back to back and lead straight into the vector read
  p_push_run_r2: assert property (@(posedge clk) disable iff (!rst_n || !hw_reset_n)
    mem_we |=> (mem_we || mem_re));

  // R3: emulation pushes stay inside the fixed stack page
  p_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !nat_q) |-> ((mem_addr >> 8) == ADDR_W'(PAGE)));

  // R5: an abort at the boundary starts the push sequence on the next cycle
  p_abort_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && hw_reset_n) |=> mem_we);

  // R8: the load cycle is the second of two vector reads
  p_vec_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (mem_re && $past(mem_re)));

  // R9: new status has interrupt disable set and decimal clear
  p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> ((status_out & 8'h0C) == 8'h04));

  // R1: after the load the sequencer is free again unless reset is requested
  p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && hw_reset_n) |=> !busy);

  // R2: squash, write and read never overlap
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({squash, mem_we, mem_re}));
endmodule

bind irq_entry_seq irq_seq_chk #(.ADDR_W(ADDR_W), .PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .busy(busy),
  .squash(squash), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .pc_load(pc_load), .status_out(status_out), .nat_q(nat_q)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic        nat;
    logic [7:0]  st;
    logic [15:0] pc;
    logic [15:0] start;
    logic [7:0]  bank;
    logic [15:0] sp;
    logic        irq_n;
    logic        abort_n;
    logic        brk;
    logic        cop;
    logic [15:0] vec;
    logic [15:0] ret;
    logic [3:0]  id;
  } case_t;

  localparam int NCASE = 9;
  localparam case_t TBL [NCASE] = '{
    {1'b1, 8'h28, 16'h1234, 16'h1230, 8'h7E, 16'h01F0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFEE, 16'h1234, 4'd2},  // R2 native maskable
    {1'b0, 8'h08, 16'h2000, 16'h1FFE, 8'h00, 16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFE, 16'h2000, 4'd3},  // R3 page wrap
    {1'b0, 8'h00, 16'h3005, 16'h3000, 8'h00, 16'h01F8, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFE, 16'h3002, 4'd6},  // R6 break, emulation
    {1'b1, 8'h30, 16'h3005, 16'h3000, 8'h12, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFE6, 16'h3002, 4'd8},  // R8 native break vector
    {1'b1, 8'h00, 16'h4402, 16'h4400, 8'h05, 16'h0200, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFE4, 16'h4402, 4'd6},  // R6 native coprocessor
    {1'b0, 8'h4B, 16'h4013, 16'h4010, 8'h00, 16'h01C0, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFF8, 16'h4010, 4'd5},  // R5 abort, emulation
    {1'b1, 8'h00, 16'h5008, 16'h5005, 8'h33, 16'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFE8, 16'h5005, 4'd10}, // R10 abort over maskable
    {1'b0, 8'h00, 16'h6002, 16'h6000, 8'h00, 16'h01A0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFE, 16'h6000, 4'd12}, // R12 maskable with break
    {1'b0, 8'hC8, 16'h7002, 16'h7000, 8'h00, 16'h0150, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFFF4, 16'h7002, 4'd7}   // R7 coprocessor status
  };

  logic        clk, rst_n, hw_reset_n, nmi_n, irq_n, abort_n, brk_trap, cop_trap, insn_done;
  logic [15:0] cur_pc, insn_start, sp_in;
  logic [7:0]  bank_in, status_in, mem_rdata;
  logic        native_in;
  logic        busy, squash, mem_we, mem_re, pc_load, native_out;
  logic [15:0] mem_addr, pc_new, sp_out;
  logic [7:0]  mem_wdata, status_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [15:0] got_addr [8];
  logic [7:0]  got_data [8];
  int          got_n;
  logic        got_load, got_nat;
  logic [15:0] got_vec, got_pc, got_sp;
  logic [7:0]  got_st;

  irq_entry_seq i_irq_entry_seq (
    .clk, .rst_n, .hw_reset_n, .nmi_n, .irq_n, .abort_n, .brk_trap, .cop_trap,
    .insn_done, .cur_pc, .insn_start, .bank_in, .status_in, .native_in, .sp_in,
    .mem_rdata, .busy, .squash, .mem_we, .mem_re, .mem_addr, .mem_wdata,
    .pc_load, .pc_new, .status_out, .native_out, .sp_out
  );

  // memory model: read byte derived from address
  assign mem_rdata = mem_addr[7:0] + 8'h30;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] id);
    case (id)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd10:   return "R10";
      4'd11:   return "R11";
      4'd12:   return "R12";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [15:0] exp_pc(input logic [15:0] v);
    return {v[7:0] + 8'h31, v[7:0] + 8'h30};
  endfunction

  task automatic run_entry(input case_t c);
    logic        sw;
    int          nexp;
    logic [15:0] ea;
    logic [7:0]  eb [4];
    @(negedge clk);
    native_in = c.nat; status_in = c.st; cur_pc = c.pc; insn_start = c.start;
    bank_in = c.bank; sp_in = c.sp; irq_n = c.irq_n; abort_n = c.abort_n;
    brk_trap = c.brk; cop_trap = c.cop; insn_done = 1'b1;
    #1;
    chk(squash == !c.abort_n, "R5", "squash at boundary", 32'(squash), 32'(!c.abort_n));
    sw = (c.brk | c.cop) & c.irq_n & c.abort_n;
    got_n = 0; got_load = 1'b0; got_vec = '0;
    for (int i = 0; i < 16 && !got_load; i++) begin
      @(negedge clk);
      if (i == 0) begin
        insn_done = 1'b0; irq_n = 1'b1; abort_n = 1'b1; brk_trap = 1'b0; cop_trap = 1'b0;
      end
      #1;
      if (mem_we && got_n < 8) begin
        got_addr[got_n] = mem_addr; got_data[got_n] = mem_wdata; got_n++;
      end
      if (mem_re && !pc_load) got_vec = mem_addr;
      if (pc_load) begin
        got_load = 1'b1; got_pc = pc_new; got_st = status_out;
        got_nat = native_out; got_sp = sp_out;
      end
    end
    nexp = c.nat ? 4 : 3;
    chk(got_n == nexp, c.nat ? "R2" : "R3", "push count", 32'(got_n), 32'(nexp));
    if (c.nat) begin
      eb[0] = c.bank; eb[1] = c.ret[15:8]; eb[2] = c.ret[7:0]; eb[3] = c.st;
    end else begin
      eb[0] = c.ret[15:8]; eb[1] = c.ret[7:0];
      eb[2] = {c.st[7:6], 1'b1, sw, c.st[3:0]}; eb[3] = 8'h00;
    end
    for (int k = 0; k < nexp && k < got_n; k++) begin
      ea = c.nat ? c.sp - 16'(k) : {8'h01, c.sp[7:0] - 8'(k)};
      chk(got_addr[k] == ea, c.nat ? "R2" : "R3", "push address", 32'(got_addr[k]), 32'(ea));
      if (k == nexp - 1)
        chk(got_data[k] == eb[k], "R7", "saved status", 32'(got_data[k]), 32'(eb[k]));
      else if (c.nat && k == 0)
        chk(got_data[k] == eb[k], "R2", "bank byte", 32'(got_data[k]), 32'(eb[k]));
      else
        chk(got_data[k] == eb[k], tag_of(c.id), "return byte", 32'(got_data[k]), 32'(eb[k]));
    end
    chk(got_load, "R8", "load reached", 32'(got_load), 32'(1));
    chk(got_vec == c.vec, "R8", "vector address", 32'(got_vec), 32'(c.vec));
    chk(got_pc == exp_pc(c.vec), "R8", "new pc", 32'(got_pc), 32'(exp_pc(c.vec)));
    chk(got_st == ((c.st | 8'h04) & 8'hF7), "R9", "new status", 32'(got_st), 32'((c.st | 8'h04) & 8'hF7));
    chk(got_nat == c.nat, "R9", "mode kept", 32'(got_nat), 32'(c.nat));
    ea = c.nat ? c.sp - 16'd4 : {8'h01, c.sp[7:0] - 8'd3};
    chk(got_sp == ea, "R13", "final stack pointer", 32'(got_sp), 32'(ea));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_reset_n = 1'b1; nmi_n = 1'b1; irq_n = 1'b1; abort_n = 1'b1;
    brk_trap = 1'b0; cop_trap = 1'b0; insn_done = 1'b0; cur_pc = '0; insn_start = '0;
    sp_in = '0; bank_in = '0; status_in = '0; native_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !mem_we && !mem_re && !pc_load && !squash, "R1", "idle after reset",
        {27'd0, busy, mem_we, mem_re, pc_load, squash}, 32'd0);

    // R1: reset request, initialisation period, reset vector
    @(negedge clk);
    hw_reset_n = 1'b0; status_in = 8'h89; sp_in = 16'h3377; native_in = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!mem_we && busy, "R1", "held in init", {30'd0, mem_we, busy}, 32'd1);
    end
    hw_reset_n = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk); #1;
      chk(!mem_re && !mem_we && busy, "R1", "init cycle", {29'd0, mem_re, mem_we, busy}, 32'd1);
    end
    @(negedge clk); #1;
    chk(mem_re && mem_addr == 16'hFFFC, "R1", "reset vector low", 32'(mem_addr), 32'hFFFC);
    @(negedge clk); #1;
    chk(pc_load && mem_addr == 16'hFFFD, "R1", "reset vector high", 32'(mem_addr), 32'hFFFD);
    chk(pc_new == 16'h2D2C, "R1", "reset pc", 32'(pc_new), 32'h2D2C);
    chk(status_out == 8'h85 && !native_out, "R1", "reset status and mode",
        {23'd0, native_out, status_out}, 32'h085);

    // table walk
    for (int n = 0; n < NCASE; n++) run_entry(TBL[n]);

    // R4: maskable request blocked by interrupt disable
    @(negedge clk);
    native_in = 1'b0; status_in = 8'h04; irq_n = 1'b0; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; irq_n = 1'b1; #1;
    chk(!busy && !mem_we, "R4", "masked request ignored", {30'd0, busy, mem_we}, 32'd0);
    @(negedge clk); #1;
    chk(!busy && !mem_we, "R4", "still idle", {30'd0, busy, mem_we}, 32'd0);

    // R11: falling edge latched between boundaries, taken despite disable flag
    nmi_n = 1'b0;
    repeat (2) @(negedge clk);
    run_entry('{nat:1'b0, st:8'h04, pc:16'h8100, start:16'h80FE, bank:8'h00, sp:16'h01E0,
                irq_n:1'b1, abort_n:1'b1, brk:1'b0, cop:1'b0, vec:16'hFFFA, ret:16'h8100, id:4'd11});
    // line still low: no second request
    @(negedge clk);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; #1;
    chk(!busy && !mem_we, "R11", "held-low line does not retrigger", {30'd0, busy, mem_we}, 32'd0);

    // R10: pending non-maskable wins over maskable
    nmi_n = 1'b1;
    @(negedge clk);
    nmi_n = 1'b0;
    @(negedge clk);
    run_entry('{nat:1'b1, st:8'h00, pc:16'h9000, start:16'h8FFD, bank:8'h44, sp:16'h0300,
                irq_n:1'b0, abort_n:1'b1, brk:1'b0, cop:1'b0, vec:16'hFFEA, ret:16'h9000, id:4'd10});
    nmi_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule